// File: doc/BRIEF.md
# Integer Arithmetic Compare Unit

This block is a 64-bit integer execution unit for the arithmetic instruction group of a processor pipeline. Each operation takes an A operand and a B operand, a 7-bit function code and a valid strobe. B is either the second register operand or an 8-bit literal that is zero-extended. The unit performs quadword (64-bit) and longword (32-bit) add and subtract, including the forms that report overflow and the forms that scale A by 4 or by 8 first. It also performs signed and unsigned compares and a byte-parallel unsigned compare that returns an 8-bit mask.

Longword operations read the low 32 bits of each operand and sign-extend the 32-bit result to 64 bits. The unit registers the result, an overflow-trap flag and an illegal-operation flag. They appear with an output valid one clock after the strobe. Between strobes the registered outputs hold their values. Fetch, the register file and multiplication belong to other blocks.

Top module: `int_arith_cmp_unit`

## Requirements
- R1: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high and low otherwise. A synchronous active-high `rst` clears `out_valid`, `result`, `trap` and `illegal` to 0.
- R2: Add codes are 0x20 for quadword (A+B, 64-bit wrap) and 0x00 for longword. The longword result is A[31:0]+B[31:0] wrapped to 32 bits, and bits 63:32 copy bit 31.
- R3: Subtract codes are 0x29 for quadword (A−B) and 0x09 for longword (A[31:0]−B[31:0]). The longword result is sign-extended from bit 31.
- R4: The scaled codes use A shifted left by 2 or by 3, with the result wrapping to the operation width. Scaled add codes are 0x22 (×4) and 0x32 (×8) for quadword, and 0x02 (×4) and 0x12 (×8) for longword. Scaled subtract codes are 0x2B and 0x3B for quadword, and 0x0B and 0x1B for longword.
- R5: Codes 0x60 (quadword) and 0x40 (longword) add as 0x20 and 0x00 do. They also set `trap` when A and B have equal sign bits and the result sign differs from A's sign. The sign bit is bit 63 for quadword and bit 31 for longword.
- R6: Codes 0x69 (quadword) and 0x49 (longword) subtract as 0x29 and 0x09 do. They also set `trap` when the sign bits of A and B differ and the result sign differs from A's sign. For every non-trapping code `trap` is 0, and the wrapped result is always written.
- R7: The 64-bit compares write 1 or 0 into `result`, with bits 63:1 zero. The codes are: equal 0x2D, signed less-or-equal 0x6D, signed less-than 0x4D, unsigned less-or-equal 0x3D and unsigned less-than 0x1D.
- R8: For code 0x0F, bit i (i = 0..7) of `result` is 1 when unsigned byte A[8i+7:8i] is greater than or equal to B[8i+7:8i]. Bits 63:8 are zero.
- R9: When `use_lit` is 1, B is `lit` zero-extended to 64 bits and `opb` is ignored.
- R10: Any other function code sets `illegal` to 1 and gives `result` = 0 and `trap` = 0. Legal codes give `illegal` = 0.
- R11: In a cycle with `in_valid` low, `result`, `trap` and `illegal` keep their values in the next cycle, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| func | input | 7 | Function code |
| opa | input | 64 | Operand A |
| opb | input | 64 | Register operand B |
| use_lit | input | 1 | Select the literal as B |
| lit | input | 8 | Literal, zero-extended |
| out_valid | output | 1 | Result qualifier, one cycle after the strobe |
| result | output | 64 | Registered result |
| trap | output | 1 | Overflow trap from the overflow-reporting codes |
| illegal | output | 1 | Unknown function code |

## Verification
Every result, trap and illegal flag is due one clock after its strobe, on the same edge that raises `out_valid`. The bench drives inputs on a falling edge and drops the strobe on the next falling edge. At that point it compares all four outputs with a reference model, which is halfway between the capturing edge and the following one. Hold behaviour is checked one more falling edge later, after the operands have changed under a low strobe. At that point `out_valid` must be low and the other outputs unchanged.

// File: rtl/iacu_pkg.sv
package iacu_pkg;

   localparam int CODE_W = 7;

   typedef enum logic [1:0] {K_ADD, K_SUB, K_CMP, K_BYTE} kind_e;
   typedef enum logic [2:0] {C_EQ, C_SLE, C_SLT, C_ULE, C_ULT} cmp_e;

   typedef struct packed {
      logic       legal;
      kind_e      kind;
      logic       is_long;
      logic [1:0] shamt;
      logic       trap_en;
      cmp_e       cmp;
   } ctrl_t;

   localparam logic [CODE_W-1:0] F_ADDL   = 7'h00;
   localparam logic [CODE_W-1:0] F_ADDLV  = 7'h40;
   localparam logic [CODE_W-1:0] F_S4ADDL = 7'h02;
   localparam logic [CODE_W-1:0] F_S8ADDL = 7'h12;
   localparam logic [CODE_W-1:0] F_ADDQ   = 7'h20;
   localparam logic [CODE_W-1:0] F_ADDQV  = 7'h60;
   localparam logic [CODE_W-1:0] F_S4ADDQ = 7'h22;
   localparam logic [CODE_W-1:0] F_S8ADDQ = 7'h32;
   localparam logic [CODE_W-1:0] F_SUBL   = 7'h09;
   localparam logic [CODE_W-1:0] F_SUBLV  = 7'h49;
   localparam logic [CODE_W-1:0] F_S4SUBL = 7'h0B;
   localparam logic [CODE_W-1:0] F_S8SUBL = 7'h1B;
   localparam logic [CODE_W-1:0] F_SUBQ   = 7'h29;
   localparam logic [CODE_W-1:0] F_SUBQV  = 7'h69;
   localparam logic [CODE_W-1:0] F_S4SUBQ = 7'h2B;
   localparam logic [CODE_W-1:0] F_S8SUBQ = 7'h3B;
   localparam logic [CODE_W-1:0] F_CEQ    = 7'h2D;
   localparam logic [CODE_W-1:0] F_CSLE   = 7'h6D;
   localparam logic [CODE_W-1:0] F_CSLT   = 7'h4D;
   localparam logic [CODE_W-1:0] F_CULE   = 7'h3D;
   localparam logic [CODE_W-1:0] F_CULT   = 7'h1D;
   localparam logic [CODE_W-1:0] F_BYTE   = 7'h0F;

endpackage

// File: rtl/iacu_decode.sv
module iacu_decode
   import iacu_pkg::*;
#(
   parameter int FUNC_W = 7
) (
   input  logic [FUNC_W-1:0] func,
   output ctrl_t             ctrl
);

   generate
      if (FUNC_W != CODE_W) begin : g_bad_func_w
         $error("iacu_decode: FUNC_W must equal the package code width");
      end
   endgenerate

   function automatic ctrl_t arith(input kind_e k, input logic lw,
                                   input logic [1:0] sh, input logic te);
      ctrl_t c;
      c.legal   = 1'b1;
      c.kind    = k;
      c.is_long = lw;
      c.shamt   = sh;
      c.trap_en = te;
      c.cmp     = C_EQ;
      return c;
   endfunction

   function automatic ctrl_t compare(input kind_e k, input cmp_e cm);
      ctrl_t c;
      c.legal   = 1'b1;
      c.kind    = k;
      c.is_long = 1'b0;
      c.shamt   = 2'd0;
      c.trap_en = 1'b0;
      c.cmp     = cm;
      return c;
   endfunction

   always_comb begin
      ctrl = '0;
      case (func)
         F_ADDL:   ctrl = arith(K_ADD, 1'b1, 2'd0, 1'b0);
         F_ADDLV:  ctrl = arith(K_ADD, 1'b1, 2'd0, 1'b1);
         F_S4ADDL: ctrl = arith(K_ADD, 1'b1, 2'd2, 1'b0);
         F_S8ADDL: ctrl = arith(K_ADD, 1'b1, 2'd3, 1'b0);
         F_ADDQ:   ctrl = arith(K_ADD, 1'b0, 2'd0, 1'b0);
         F_ADDQV:  ctrl = arith(K_ADD, 1'b0, 2'd0, 1'b1);
         F_S4ADDQ: ctrl = arith(K_ADD, 1'b0, 2'd2, 1'b0);
         F_S8ADDQ: ctrl = arith(K_ADD, 1'b0, 2'd3, 1'b0);
         F_SUBL:   ctrl = arith(K_SUB, 1'b1, 2'd0, 1'b0);
         F_SUBLV:  ctrl = arith(K_SUB, 1'b1, 2'd0, 1'b1);
         F_S4SUBL: ctrl = arith(K_SUB, 1'b1, 2'd2, 1'b0);
         F_S8SUBL: ctrl = arith(K_SUB, 1'b1, 2'd3, 1'b0);
         F_SUBQ:   ctrl = arith(K_SUB, 1'b0, 2'd0, 1'b0);
         F_SUBQV:  ctrl = arith(K_SUB, 1'b0, 2'd0, 1'b1);
         F_S4SUBQ: ctrl = arith(K_SUB, 1'b0, 2'd2, 1'b0);
         F_S8SUBQ: ctrl = arith(K_SUB, 1'b0, 2'd3, 1'b0);
         F_CEQ:    ctrl = compare(K_CMP, C_EQ);
         F_CSLE:   ctrl = compare(K_CMP, C_SLE);
         F_CSLT:   ctrl = compare(K_CMP, C_SLT);
         F_CULE:   ctrl = compare(K_CMP, C_ULE);
         F_CULT:   ctrl = compare(K_CMP, C_ULT);
         F_BYTE:   ctrl = compare(K_BYTE, C_EQ);
         default:  ctrl = '0;
      endcase
   end

endmodule

// File: rtl/iacu_addsub.sv
module iacu_addsub #(
   parameter int DATA_W = 64,
   parameter int HALF_W = 32
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic              sub,
   input  logic              is_long,
   input  logic [1:0]        shamt,
   output logic [DATA_W-1:0] res,
   output logic              ovf
);

   localparam int EXT_W = DATA_W - HALF_W;

   logic [DATA_W-1:0] a_sc;
   logic [HALF_W-1:0] al, bl, rl;
   logic [DATA_W-1:0] rq;
   logic [DATA_W-1:0] rl_ext;
   logic              ovf_l, ovf_q;

   assign a_sc = a << shamt;
   assign al   = a_sc[HALF_W-1:0];
   assign bl   = b[HALF_W-1:0];
   assign rl   = sub ? (al - bl) : (al + bl);
   assign rq   = sub ? (a_sc - b) : (a_sc + b);

   generate
      if (EXT_W > 0) begin : g_ext
         assign rl_ext = {{EXT_W{rl[HALF_W-1]}}, rl};
      end else begin : g_noext
         assign rl_ext = rl;
      end
   endgenerate

   // Same-sign rule for add, opposite-sign rule for subtract.
   assign ovf_l = ((al[HALF_W-1] ^ bl[HALF_W-1]) == sub) &&
                  (rl[HALF_W-1] != al[HALF_W-1]);
   assign ovf_q = ((a_sc[DATA_W-1] ^ b[DATA_W-1]) == sub) &&
                  (rq[DATA_W-1] != a_sc[DATA_W-1]);

   assign res = is_long ? rl_ext : rq;
   assign ovf = is_long ? ovf_l : ovf_q;

endmodule

// File: rtl/iacu_compare.sv
module iacu_compare
   import iacu_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int LANE_W = 8
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  cmp_e              cmp,
   output logic [DATA_W-1:0] cmp_res,
   output logic [DATA_W-1:0] byte_res
);

   localparam int LANES = DATA_W / LANE_W;

   logic             eq, slt, ult, bit_out;
   logic [LANES-1:0] mask;

   assign eq  = (a == b);
   assign slt = ($signed(a) < $signed(b));
   assign ult = (a < b);

   always_comb begin
      case (cmp)
         C_EQ:    bit_out = eq;
         C_SLE:   bit_out = slt | eq;
         C_SLT:   bit_out = slt;
         C_ULE:   bit_out = ult | eq;
         C_ULT:   bit_out = ult;
         default: bit_out = 1'b0;
      endcase
   end

   genvar i;
   generate
      for (i = 0; i < LANES; i++) begin : g_lane
         assign mask[i] = (a[i*LANE_W +: LANE_W] >= b[i*LANE_W +: LANE_W]);
      end
      if (LANES < DATA_W) begin : g_pad
         assign byte_res = {{(DATA_W-LANES){1'b0}}, mask};
      end else begin : g_nopad
         assign byte_res = mask;
      end
   endgenerate

   assign cmp_res = {{(DATA_W-1){1'b0}}, bit_out};

endmodule

// File: rtl/int_arith_cmp_unit.sv
module int_arith_cmp_unit
   import iacu_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int HALF_W = 32,
   parameter int LIT_W  = 8,
   parameter int FUNC_W = 7,
   parameter int LANE_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [FUNC_W-1:0] func,
   input  logic [DATA_W-1:0] opa,
   input  logic [DATA_W-1:0] opb,
   input  logic              use_lit,
   input  logic [LIT_W-1:0]  lit,
   output logic              out_valid,
   output logic [DATA_W-1:0] result,
   output logic              trap,
   output logic              illegal
);

   localparam int LANES = DATA_W / LANE_W;

   generate
      if (DATA_W != 2 * HALF_W) begin : g_bad_half
         $error("int_arith_cmp_unit: HALF_W must be half of DATA_W");
      end
      if ((DATA_W % LANE_W) != 0) begin : g_bad_lane
         $error("int_arith_cmp_unit: LANE_W must divide DATA_W");
      end
      if (LIT_W >= DATA_W) begin : g_bad_lit
         $error("int_arith_cmp_unit: LIT_W must be narrower than DATA_W");
      end
   endgenerate

   ctrl_t             ctrl;
   logic [DATA_W-1:0] b_eff;
   logic [DATA_W-1:0] as_res, cmp_res, byte_res;
   logic              as_ovf;
   logic [DATA_W-1:0] n_res;
   logic              n_trap;

   logic              r_long, r_trapen;
   kind_e             r_kind;

   assign b_eff = use_lit ? {{(DATA_W-LIT_W){1'b0}}, lit} : opb;

   iacu_decode #(.FUNC_W(FUNC_W)) u_dec (
      .func (func),
      .ctrl (ctrl)
   );

   iacu_addsub #(.DATA_W(DATA_W), .HALF_W(HALF_W)) u_as (
      .a       (opa),
      .b       (b_eff),
      .sub     (ctrl.kind == K_SUB),
      .is_long (ctrl.is_long),
      .shamt   (ctrl.shamt),
      .res     (as_res),
      .ovf     (as_ovf)
   );

   iacu_compare #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_cmp (
      .a        (opa),
      .b        (b_eff),
      .cmp      (ctrl.cmp),
      .cmp_res  (cmp_res),
      .byte_res (byte_res)
   );

   always_comb begin
      n_res  = '0;
      n_trap = 1'b0;
      if (ctrl.legal) begin
         case (ctrl.kind)
            K_ADD, K_SUB: begin
               n_res  = as_res;
               n_trap = ctrl.trap_en & as_ovf;
            end
            K_CMP:   n_res = cmp_res;
            K_BYTE:  n_res = byte_res;
            default: n_res = '0;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         result    <= '0;
         trap      <= 1'b0;
         illegal   <= 1'b0;
         r_long    <= 1'b0;
         r_trapen  <= 1'b0;
         r_kind    <= K_ADD;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            result   <= n_res;
            trap     <= n_trap;
            illegal  <= ~ctrl.legal;
            r_long   <= ctrl.is_long & ctrl.legal;
            r_trapen <= ctrl.trap_en & ctrl.legal;
            r_kind   <= ctrl.kind;
         end
      end
   end

   // R1
   valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);

   // R1
   valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);

   // R11
   hold_result_chk: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> ($stable(result) && $stable(trap) && $stable(illegal)));

   // R6
   no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
      (out_valid && trap) |-> (r_trapen && !illegal));

   // R10
   illegal_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (out_valid && illegal) |-> (result == '0 && !trap));

   // R2
   long_sext_chk: assert property (@(posedge clk) disable iff (rst)
      (out_valid && r_long) |->
         (result[DATA_W-1:HALF_W] == {(DATA_W-HALF_W){result[HALF_W-1]}}));

   // R7
   cmp_bit_chk: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !illegal && r_kind == K_CMP) |->
         (result[DATA_W-1:1] == '0));

   // R8
   byte_mask_chk: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !illegal && r_kind == K_BYTE) |->
         (result[DATA_W-1:LANES] == '0));

endmodule

// File: tb/tb_int_arith_cmp_unit.sv
`timescale 1ns/1ps
module tb_int_arith_cmp_unit;

   logic        clk = 1'b0;
   logic        rst;
   logic        in_valid;
   logic [6:0]  func;
   logic [63:0] opa, opb;
   logic        use_lit;
   logic [7:0]  lit;
   logic        out_valid;
   logic [63:0] result;
   logic        trap, illegal;

   int checks = 0;
   int failures = 0;

   always #10 clk = ~clk;

   int_arith_cmp_unit dut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .func(func),
      .opa(opa), .opb(opb), .use_lit(use_lit), .lit(lit),
      .out_valid(out_valid), .result(result), .trap(trap), .illegal(illegal)
   );

   logic [6:0] codes [22] = '{7'h00, 7'h40, 7'h02, 7'h12, 7'h20, 7'h60, 7'h22,
      7'h32, 7'h09, 7'h49, 7'h0B, 7'h1B, 7'h29, 7'h69, 7'h2B, 7'h3B, 7'h2D,
      7'h6D, 7'h4D, 7'h3D, 7'h1D, 7'h0F};

   function automatic string tag_of(input logic [6:0] f);
      case (f)
         7'h00, 7'h20: return "R2";
         7'h09, 7'h29: return "R3";
         7'h02, 7'h12, 7'h22, 7'h32, 7'h0B, 7'h1B, 7'h2B, 7'h3B: return "R4";
         7'h40, 7'h60: return "R5";
         7'h49, 7'h69: return "R6";
         7'h2D, 7'h6D, 7'h4D, 7'h3D, 7'h1D: return "R7";
         7'h0F: return "R8";
         default: return "R10";
      endcase
   endfunction

   function automatic void model(input logic [6:0] f, input logic [63:0] a,
                                 input logic [63:0] b, output logic [63:0] r,
                                 output logic t, output logic il);
      logic        sub, lw, te;
      int          sh;
      logic [63:0] as, rq;
      logic [31:0] r32;
      r = 0; t = 0; il = 0; sub = 0; lw = 0; te = 0; sh = 0;
      case (f)
         7'h00: lw = 1;
         7'h40: begin lw = 1; te = 1; end
         7'h02: begin lw = 1; sh = 2; end
         7'h12: begin lw = 1; sh = 3; end
         7'h20: ;
         7'h60: te = 1;
         7'h22: sh = 2;
         7'h32: sh = 3;
         7'h09: begin sub = 1; lw = 1; end
         7'h49: begin sub = 1; lw = 1; te = 1; end
         7'h0B: begin sub = 1; lw = 1; sh = 2; end
         7'h1B: begin sub = 1; lw = 1; sh = 3; end
         7'h29: sub = 1;
         7'h69: begin sub = 1; te = 1; end
         7'h2B: begin sub = 1; sh = 2; end
         7'h3B: begin sub = 1; sh = 3; end
         7'h2D: begin r = {63'd0, a == b}; return; end
         7'h6D: begin r = {63'd0, $signed(a) <= $signed(b)}; return; end
         7'h4D: begin r = {63'd0, $signed(a) < $signed(b)}; return; end
         7'h3D: begin r = {63'd0, a <= b}; return; end
         7'h1D: begin r = {63'd0, a < b}; return; end
         7'h0F: begin
            for (int i = 0; i < 8; i++) r[i] = (a[8*i +: 8] >= b[8*i +: 8]);
            return;
         end
         default: begin il = 1; return; end
      endcase
      as = a << sh;
      if (lw) begin
         r32 = sub ? as[31:0] - b[31:0] : as[31:0] + b[31:0];
         r = {{32{r32[31]}}, r32};
         if (te) t = (sub ? (a[31] != b[31]) : (a[31] == b[31])) && (r32[31] != a[31]);
      end else begin
         rq = sub ? as - b : as + b;
         r = rq;
         if (te) t = (sub ? (a[63] != b[63]) : (a[63] == b[63])) && (rq[63] != a[63]);
      end
   endfunction

   task automatic check1(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic run_op(input logic [6:0] f, input logic [63:0] a,
                         input logic [63:0] b, input logic ul, input logic [7:0] l,
                         input bit hold_chk);
      logic [63:0] be, er;
      logic        et, ei;
      string       req;
      be = ul ? {56'd0, l} : b;
      model(f, a, be, er, et, ei);
      req = ul ? "R9" : tag_of(f);
      @(negedge clk);
      func = f; opa = a; opb = b; use_lit = ul; lit = l; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0; opa = ~a; opb = ~b; func = 7'h7F;
      check1("R1", "out_valid", {63'd0, out_valid}, 64'd1);
      check1(req, "result", result, er);
      check1(req, "trap", {63'd0, trap}, {63'd0, et});
      check1(req, "illegal", {63'd0, illegal}, {63'd0, ei});
      if (hold_chk) begin
         @(negedge clk);
         check1("R1", "out_valid idle", {63'd0, out_valid}, 64'd0);
         check1("R11", "result hold", result, er);
         check1("R11", "trap hold", {63'd0, trap}, {63'd0, et});
         check1("R11", "illegal hold", {63'd0, illegal}, {63'd0, ei});
      end
   endtask

   initial begin
      #(20 * 150000);
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      int unused_seed;
      unused_seed = $urandom(32'h5EED_1234);
      rst = 1'b1; in_valid = 1'b0; func = 7'h00; opa = 64'hFFFF_FFFF_FFFF_FFFF;
      opb = 64'h1; use_lit = 1'b0; lit = 8'h0;
      repeat (3) @(negedge clk);
      // R1 reset state
      check1("R1", "reset out_valid", {63'd0, out_valid}, 64'd0);
      check1("R1", "reset result", result, 64'd0);
      check1("R1", "reset trap", {63'd0, trap}, 64'd0);
      check1("R1", "reset illegal", {63'd0, illegal}, 64'd0);
      rst = 1'b0;

      // R5 longword overflow on trapping add, plain add does not trap
      run_op(7'h40, 64'h7FFF_FFFF, 64'h1, 0, 0, 1);
      run_op(7'h00, 64'h7FFF_FFFF, 64'h1, 0, 0, 1);
      run_op(7'h60, 64'h7FFF_FFFF_FFFF_FFFF, 64'h1, 0, 0, 0);
      run_op(7'h60, 64'h8000_0000_0000_0000, 64'h1, 0, 0, 0);
      // R6 subtract overflow cases
      run_op(7'h49, 64'h8000_0000, 64'h1, 0, 0, 1);
      run_op(7'h69, 64'h0, 64'h8000_0000_0000_0000, 0, 0, 0);
      run_op(7'h69, 64'h5, 64'h3, 0, 0, 0);
      // R2 R3 sign extension of longword results
      run_op(7'h00, 64'hAAAA_AAAA_8000_0000, 64'h5555_5555_0000_0001, 0, 0, 0);
      run_op(7'h09, 64'h0, 64'h1, 0, 0, 0);
      // R4 scaled forms
      run_op(7'h32, 64'h1, 64'h0, 0, 0, 0);
      run_op(7'h0B, 64'h1, 64'h5, 0, 0, 0);
      run_op(7'h12, 64'h2000_0000, 64'h7, 0, 0, 0);
      // R7 signed vs unsigned
      run_op(7'h4D, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 0, 0, 0);
      run_op(7'h1D, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 0, 0, 0);
      run_op(7'h6D, 64'h7, 64'h7, 0, 0, 0);
      run_op(7'h2D, 64'h7, 64'h8, 0, 0, 0);
      // R8 byte mask
      run_op(7'h0F, 64'h00FF_1080_7F01_0203, 64'h0100_1081_7E01_0302, 0, 0, 1);
      // R9 literal zero-extended
      run_op(7'h20, 64'h1, 64'hDEAD_BEEF, 1, 8'hFF, 0);
      run_op(7'h2D, 64'h80, 64'h0, 1, 8'h80, 0);
      // R10 unknown codes
      run_op(7'h7F, 64'h1234, 64'h5678, 0, 0, 1);
      run_op(7'h01, 64'h1234, 64'h5678, 0, 0, 0);

      for (int n = 0; n < 400; n++) begin
         logic [6:0]  f;
         logic [63:0] a, b;
         if ((n % 16) == 15) f = 7'($urandom);
         else f = codes[$urandom % 22];
         a = {$urandom, $urandom};
         b = {$urandom, $urandom};
         if ((n % 5) == 0) b[63] = a[63];
         if ((n % 7) == 0) b[31] = a[31];
         run_op(f, a, b, ($urandom % 4) == 0, 8'($urandom), (n % 8) == 0);
      end

      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule